// File: doc/BRIEF.md
# Low-precision float to FP32 decoder

This block widens a single low-precision floating-point element into an IEEE-754 single-precision word. Each input lane is eight bits wide. A three-bit type code picks one of five element layouts: two 8-bit layouts, two 6-bit layouts and one 4-bit layout. A one-bit flavour flag applies to the two 8-bit layouts. When it is set, they use the unsigned-zero finite convention, which has a single NaN pattern. When it is clear, they use the open standard convention. Narrower elements sit right-aligned in the lane.

Every value of every layout fits exactly in FP32, so the datapath never rounds. Subnormal elements are renormalised with a leading-one search and come out as normal FP32 numbers. Zero, infinity and NaN are classified per layout. Every NaN, and every illegal type code, maps to one canonical quiet NaN. The converted word and a valid strobe are registered and appear one clock after the request.

Top module: `lpf_to_fp32`

## Requirements
- R1: While rst_ni is low and after its release, until the first accepted request, out_valid_o is 0 and result_o is 0x00000000.
- R2: out_valid_o is high in exactly the cycle after a clock edge that samples in_valid_i high, so back-to-back requests give back-to-back results. result_o keeps its last value in cycles with no request.
- R3: The type codes are 0 = E4M3, 1 = E5M2, 2 = E2M3, 3 = E3M2 and 4 = E2M1. The element occupies lane bits [W-1:0], where W is 8, 8, 6, 6 or 4. The sign is bit W-1, the exponent field comes next down, and the mantissa sits in the low bits. Lane bits at or above W are ignored.
- R4: A nonzero, non-reserved exponent E with mantissa M gives (-1)^S·1.M·2^(E−bias). The biases are: E4M3 7 (flag 0) or 8 (flag 1); E5M2 15 (flag 0) or 16 (flag 1); E2M3 1; E3M2 3; E2M1 1. fnuz_i has no effect for codes 2 to 4.
- R5: A zero exponent with a nonzero mantissa gives (-1)^S·0.M·2^(1−bias), emitted as a normal FP32 number. The output never has a zero exponent field together with a nonzero fraction.
- R6: A zero exponent and zero mantissa gives a zero with the input sign, for flag 0 and for codes 2 to 4. With flag 1 on codes 0 and 1, lane 0x00 gives +0.0 and the result is never 0x80000000.
- R7: E4M3 with flag 0 has no infinity. Lanes 0x7F and 0xFF give 0x7FC00000, and 0x7E gives 448.0 (0x43E00000). Every NaN output equals 0x7FC00000.
- R8: With flag 1 on codes 0 and 1, lane 0x80 is the only NaN and gives 0x7FC00000. All-ones exponents are finite: E4M3 0x7F gives 240.0 (0x43700000), and E5M2 0xFF gives -57344.0 (0xC7600000).
- R9: E5M2 with flag 0 maps an exponent of 11111 with mantissa 00 to signed infinity (0x7C gives 0x7F800000, 0xFC gives 0xFF800000). With a nonzero mantissa it gives 0x7FC00000.
- R10: Codes 2 to 4 have no reserved encodings. The largest magnitudes are 7.5 (0x40F00000), 28.0 (0x41E00000) and 6.0 (0x40C00000).
- R11: Type codes 5, 6 and 7 give 0x7FC00000 for any lane value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe; lane, type and flag are sampled when high |
| elem_i | input | 8 | Element lane, right-aligned for narrow types |
| fmt_i | input | 3 | Element type code |
| fnuz_i | input | 1 | 8-bit flavour: 1 unsigned-zero finite, 0 open standard |
| out_valid_o | output | 1 | Result strobe, one clock after the request |
| result_o | output | 32 | FP32 encoding of the element |

## Verification
The latency property compares out_valid_o with the strobe of the previous edge. It therefore assumes that in_valid_i stays low while rst_ni is low. The stimulus holds the strobe idle until reset is released. The unsigned-zero property reads fmt_i and fnuz_i only in cycles where in_valid_i is high, and the bench changes lane, type and flag only at falling clock edges together with the strobe. The combinational checks on the leading-one position and the exponent range apply only to legal, non-special elements, which the stimulus reaches for every code and lane value.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  localparam int ELEM_W     = 8;
  localparam int FMT_W      = 3;
  localparam int EXP_MAXW   = 5;
  localparam int MAN_MAXW   = 3;
  localparam int POS_W      = $clog2(MAN_MAXW);
  localparam int F32_EXP_W  = 8;
  localparam int F32_FRAC_W = 23;
  localparam int F32_W      = 1 + F32_EXP_W + F32_FRAC_W;
  localparam int F32_BIAS   = 127;
  localparam int EXPW_W     = $clog2(EXP_MAXW + 1);
  localparam int MANW_W     = $clog2(MAN_MAXW + 1);
  localparam int WEXP_W     = F32_EXP_W + 1;
  localparam logic [F32_W-1:0] QNAN = 32'h7FC0_0000;

  typedef enum logic [FMT_W-1:0] {
    FMT_E4M3 = 3'd0,
    FMT_E5M2 = 3'd1,
    FMT_E2M3 = 3'd2,
    FMT_E3M2 = 3'd3,
    FMT_E2M1 = 3'd4
  } fmt_e;

  typedef struct packed {
    logic                legal;
    logic                uzero;   // unsigned-zero finite flavour active
    logic                sat_e4;  // all-ones exp+man is NaN
    logic                inf_e5;  // all-ones exp is inf/NaN
    logic [EXPW_W-1:0]   exp_w;
    logic [MANW_W-1:0]   man_w;
    logic [EXP_MAXW-1:0] bias;
  } fmt_info_t;

  function automatic fmt_info_t fmt_lookup(input logic [FMT_W-1:0] code, input logic fnuz);
    fmt_info_t f;
    f.legal  = 1'b1;
    f.uzero  = 1'b0;
    f.sat_e4 = 1'b0;
    f.inf_e5 = 1'b0;
    f.exp_w  = EXPW_W'(4);
    f.man_w  = MANW_W'(3);
    f.bias   = EXP_MAXW'(7);
    case (code)
      FMT_E4M3: begin
        f.uzero  = fnuz;
        f.sat_e4 = !fnuz;
        f.bias   = fnuz ? EXP_MAXW'(8) : EXP_MAXW'(7);
      end
      FMT_E5M2: begin
        f.uzero  = fnuz;
        f.inf_e5 = !fnuz;
        f.exp_w  = EXPW_W'(5);
        f.man_w  = MANW_W'(2);
        f.bias   = fnuz ? EXP_MAXW'(16) : EXP_MAXW'(15);
      end
      FMT_E2M3: begin
        f.exp_w = EXPW_W'(2);
        f.man_w = MANW_W'(3);
        f.bias  = EXP_MAXW'(1);
      end
      FMT_E3M2: begin
        f.exp_w = EXPW_W'(3);
        f.man_w = MANW_W'(2);
        f.bias  = EXP_MAXW'(3);
      end
      FMT_E2M1: begin
        f.exp_w = EXPW_W'(2);
        f.man_w = MANW_W'(1);
        f.bias  = EXP_MAXW'(1);
      end
      default: f.legal = 1'b0;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/lpf_fields.sv
module lpf_fields
  import lpf_pkg::*;
(
  input  logic [ELEM_W-1:0]   elem_i,
  input  fmt_info_t           info_i,
  output logic                sign_o,
  output logic [EXP_MAXW-1:0] exp_o,
  output logic [MAN_MAXW-1:0] man_la_o,
  output logic                exp_ones_o,
  output logic                man_ones_o
);
  logic [EXP_MAXW:0]   ones_sh;
  logic [EXP_MAXW-1:0] exp_mask;
  logic [MAN_MAXW-1:0] man_mask;
  logic [MAN_MAXW-1:0] man_raw;
  logic [2:0]          sign_pos;

  always_comb begin
    ones_sh    = (EXP_MAXW+1)'(1) << info_i.exp_w;
    exp_mask   = EXP_MAXW'(ones_sh - (EXP_MAXW+1)'(1));
    man_mask   = MAN_MAXW'(((MAN_MAXW+1)'(1) << info_i.man_w) - (MAN_MAXW+1)'(1));
    sign_pos   = 3'(info_i.exp_w) + 3'(info_i.man_w);
    sign_o     = elem_i[sign_pos];
    exp_o      = EXP_MAXW'(elem_i >> info_i.man_w) & exp_mask;
    man_raw    = elem_i[MAN_MAXW-1:0] & man_mask;
    // left-align so bit MAN_MAXW-1 always weighs 1/2
    man_la_o   = man_raw << (MANW_W'(MAN_MAXW) - info_i.man_w);
    exp_ones_o = (exp_o == exp_mask);
    man_ones_o = (man_raw == man_mask);
  end
endmodule

// File: rtl/lpf_lzd.sv
module lpf_lzd #(
  parameter int W  = 3,
  parameter int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o,
  output logic          found_o
);
  logic [W-1:0] hi;

  for (genvar i = 0; i < W; i++) begin : g_hi
    if (i == W - 1) begin : g_top
      assign hi[i] = vec_i[i];
    end else begin : g_low
      assign hi[i] = vec_i[i] & ~(|vec_i[W-1:i+1]);
    end
  end

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (hi[i]) pos_o = pos_o | PW'(i);
    end
  end

  assign found_o = |vec_i;

  always_comb begin
    if (found_o) begin
      // R5
      lzd_lead_chk: assert ((vec_i >> pos_o) == W'(1));
    end
  end
endmodule

// File: rtl/lpf_pack.sv
module lpf_pack
  import lpf_pkg::*;
(
  input  fmt_info_t           info_i,
  input  logic                sign_i,
  input  logic [EXP_MAXW-1:0] exp_i,
  input  logic [MAN_MAXW-1:0] man_la_i,
  input  logic                exp_ones_i,
  input  logic                man_ones_i,
  input  logic [POS_W-1:0]    lead_i,
  input  logic                nz_man_i,
  output logic [F32_W-1:0]    word_o
);
  logic                  exp_zero, is_zero, is_sub, is_nan, is_inf;
  logic [WEXP_W-1:0]     wexp;
  logic [MAN_MAXW-1:0]   frac_hi;
  logic [F32_FRAC_W-1:0] frac;

  always_comb begin
    exp_zero = (exp_i == '0);
    is_zero  = exp_zero && !nz_man_i;
    is_sub   = exp_zero && nz_man_i;
    is_nan   = !info_i.legal
             || (info_i.uzero && sign_i && is_zero)
             || (info_i.sat_e4 && exp_ones_i && man_ones_i)
             || (info_i.inf_e5 && exp_ones_i && nz_man_i);
    is_inf   = info_i.inf_e5 && exp_ones_i && !nz_man_i;

    if (is_sub) begin
      // 0.m * 2^(1-bias) with leading one at lead_i of left-aligned m
      wexp    = WEXP_W'(lead_i) + WEXP_W'(F32_BIAS + 1 - MAN_MAXW) - WEXP_W'(info_i.bias);
      frac_hi = man_la_i << (MANW_W'(MAN_MAXW) - MANW_W'(lead_i));
    end else begin
      wexp    = WEXP_W'(exp_i) + WEXP_W'(F32_BIAS) - WEXP_W'(info_i.bias);
      frac_hi = man_la_i;
    end
    frac = {frac_hi, {(F32_FRAC_W-MAN_MAXW){1'b0}}};

    if (is_nan)       word_o = QNAN;
    else if (is_inf)  word_o = {sign_i, {F32_EXP_W{1'b1}}, {F32_FRAC_W{1'b0}}};
    else if (is_zero) word_o = {sign_i & ~info_i.uzero, {(F32_W-1){1'b0}}};
    else              word_o = {sign_i, wexp[F32_EXP_W-1:0], frac};
  end

  always_comb begin
    if (!is_nan && !is_inf && !is_zero) begin
      // R4
      exp_range_chk: assert (wexp != '0 && wexp < WEXP_W'((1 << F32_EXP_W) - 1));
    end
  end
endmodule

// File: rtl/lpf_to_fp32.sv
module lpf_to_fp32
  import lpf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic              fnuz_i,
  output logic              out_valid_o,
  output logic [F32_W-1:0]  result_o
);
  fmt_info_t           info;
  logic                sign, exp_ones, man_ones, nz_man;
  logic [EXP_MAXW-1:0] exp_f;
  logic [MAN_MAXW-1:0] man_la;
  logic [POS_W-1:0]    lead;
  logic [F32_W-1:0]    word;

  assign info = fmt_lookup(fmt_i, fnuz_i);

  lpf_fields u_fields (
    .elem_i     (elem_i),
    .info_i     (info),
    .sign_o     (sign),
    .exp_o      (exp_f),
    .man_la_o   (man_la),
    .exp_ones_o (exp_ones),
    .man_ones_o (man_ones)
  );

  lpf_lzd #(.W(MAN_MAXW), .PW(POS_W)) u_lzd (
    .vec_i   (man_la),
    .pos_o   (lead),
    .found_o (nz_man)
  );

  lpf_pack u_pack (
    .info_i     (info),
    .sign_i     (sign),
    .exp_i      (exp_f),
    .man_la_i   (man_la),
    .exp_ones_i (exp_ones),
    .man_ones_i (man_ones),
    .lead_i     (lead),
    .nz_man_i   (nz_man),
    .word_o     (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) result_o <= word;
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));

  // R5
  no_denorm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && result_o[F32_W-2 -: F32_EXP_W] == '0) |-> result_o[F32_FRAC_W-1:0] == '0);

  // R7
  nan_canon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (&result_o[F32_W-2 -: F32_EXP_W]) && (|result_o[F32_FRAC_W-1:0]))
      |-> result_o == QNAN);

  // R6
  uzero_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fnuz_i && fmt_i <= FMT_W'(1)) |=> result_o != 32'h8000_0000);
endmodule

// File: tb/lpf_to_fp32_test.sv
module lpf_to_fp32_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NAN_W = 32'h7FC0_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  elem_i = '0;
  logic [2:0]  fmt_i = '0;
  logic        fnuz_i = 1'b0;
  logic        out_valid_o;
  logic [31:0] result_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_en  = 1'b0;
  bit done    = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  lpf_to_fp32 uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .elem_i      (elem_i),
    .fmt_i       (fmt_i),
    .fnuz_i      (fnuz_i),
    .out_valid_o (out_valid_o),
    .result_o    (result_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic real pow2(input int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else        for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic logic [31:0] to_bits(input bit s, input real mag);
    real x = mag;
    int  ex = 0;
    logic [7:0]  be;
    logic [22:0] bf;
    while (x >= 2.0) begin x = x / 2.0; ex++; end
    while (x < 1.0)  begin x = x * 2.0; ex--; end
    be = 8'(ex + 127);
    bf = 23'(int'((x - 1.0) * 8388608.0));
    return {s, be, bf};
  endfunction

  function automatic logic [31:0] ref_word(input logic [7:0] el, input int fc, input bit nz);
    int  ew, mw, bias, e, m;
    bit  s, wide;
    real v;
    case (fc)
      0: begin ew = 4; mw = 3; bias = nz ? 8 : 7;   end
      1: begin ew = 5; mw = 2; bias = nz ? 16 : 15; end
      2: begin ew = 2; mw = 3; bias = 1; end
      3: begin ew = 3; mw = 2; bias = 3; end
      4: begin ew = 2; mw = 1; bias = 1; end
      default: return NAN_W;
    endcase
    wide = (fc < 2);
    s = el[ew+mw];
    e = (int'(el) >> mw) & ((1 << ew) - 1);
    m = int'(el) & ((1 << mw) - 1);
    if (wide && nz && el == 8'h80) return NAN_W;
    if (fc == 0 && !nz && e == 15 && m == 7) return NAN_W;
    if (fc == 1 && !nz && e == 31) return (m == 0) ? {s, 8'hFF, 23'd0} : NAN_W;
    if (e == 0 && m == 0) return {s && !(wide && nz), 31'd0};
    if (e == 0) v = (real'(m) / pow2(mw)) * pow2(1 - bias);
    else        v = (1.0 + real'(m) / pow2(mw)) * pow2(e - bias);
    return to_bits(s, v);
  endfunction

  task automatic drive(input logic [7:0] el, input logic [2:0] fc, input logic nz,
                       input logic [31:0] ex, input string tag);
    elem_i     = el;
    fmt_i      = fc;
    fnuz_i     = nz;
    in_valid_i = 1'b1;
    exp_q.push_back(ex);
    tag_q.push_back(tag);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    in_valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: pops one expected item per result strobe
  initial begin
    forever begin
      @(negedge clk_i);
      if (mon_en && out_valid_o) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected strobe", out_valid_o, 32'd0);
        end else begin
          check(tag_q.pop_front(), result_o, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", out_valid_o, 32'd0);
    check("R1 result in reset", result_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid after release", out_valid_o, 32'd0);
    check("R1 result after release", result_o, 32'd0);
    mon_en = 1'b1;

    // R3: upper lane bits ignored for narrow types
    drive(8'hC8, 3'd2, 1'b0, 32'h3F80_0000, "R3 E2M3 upper bits");
    drive(8'hCC, 3'd3, 1'b0, 32'h3F80_0000, "R3 E3M2 upper bits");
    drive(8'hF2, 3'd4, 1'b0, 32'h3F80_0000, "R3 E2M1 upper bits");
    idle(1);
    // R4: biases and flag selection
    drive(8'h38, 3'd0, 1'b0, 32'h3F80_0000, "R4 E4M3 bias7");
    drive(8'h38, 3'd0, 1'b1, 32'h3F00_0000, "R4 E4M3 bias8");
    drive(8'h3C, 3'd1, 1'b0, 32'h3F80_0000, "R4 E5M2 bias15");
    drive(8'h3C, 3'd1, 1'b1, 32'h3F00_0000, "R4 E5M2 bias16");
    drive(8'h08, 3'd2, 1'b1, 32'h3F80_0000, "R4 flag ignored E2M3");
    drive(8'h0C, 3'd3, 1'b1, 32'h3F80_0000, "R4 flag ignored E3M2");
    idle(2);
    // R5: subnormals
    drive(8'h01, 3'd0, 1'b0, 32'h3B00_0000, "R5 E4M3 min sub");
    drive(8'h01, 3'd0, 1'b1, 32'h3A80_0000, "R5 E4M3 uzero min sub");
    drive(8'h03, 3'd1, 1'b0, 32'h3840_0000, "R5 E5M2 sub");
    drive(8'h01, 3'd4, 1'b0, 32'h3F00_0000, "R5 E2M1 sub");
    drive(8'h05, 3'd2, 1'b0, 32'h3F20_0000, "R5 E2M3 sub");
    // R6: zeros
    drive(8'h80, 3'd0, 1'b0, 32'h8000_0000, "R6 E4M3 negative zero");
    drive(8'h00, 3'd0, 1'b1, 32'h0000_0000, "R6 uzero zero");
    drive(8'h08, 3'd4, 1'b0, 32'h8000_0000, "R6 E2M1 negative zero");
    idle(1);
    // R7
    drive(8'h7F, 3'd0, 1'b0, NAN_W,          "R7 E4M3 +NaN");
    drive(8'hFF, 3'd0, 1'b0, NAN_W,          "R7 E4M3 -NaN");
    drive(8'h7E, 3'd0, 1'b0, 32'h43E0_0000,  "R7 E4M3 max 448");
    // R8
    drive(8'h80, 3'd0, 1'b1, NAN_W,          "R8 E4M3 uzero NaN");
    drive(8'h80, 3'd1, 1'b1, NAN_W,          "R8 E5M2 uzero NaN");
    drive(8'h7F, 3'd0, 1'b1, 32'h4370_0000,  "R8 E4M3 uzero max 240");
    drive(8'hFF, 3'd1, 1'b1, 32'hC760_0000,  "R8 E5M2 uzero -57344");
    drive(8'h7C, 3'd1, 1'b1, 32'h4700_0000,  "R8 E5M2 uzero no inf");
    // R9
    drive(8'h7C, 3'd1, 1'b0, 32'h7F80_0000,  "R9 +inf");
    drive(8'hFC, 3'd1, 1'b0, 32'hFF80_0000,  "R9 -inf");
    drive(8'h7D, 3'd1, 1'b0, NAN_W,          "R9 NaN");
    drive(8'hFF, 3'd1, 1'b0, NAN_W,          "R9 -NaN");
    drive(8'h7B, 3'd1, 1'b0, 32'h4760_0000,  "R9 max finite");
    // R10
    drive(8'h1F, 3'd2, 1'b0, 32'h40F0_0000,  "R10 E2M3 max");
    drive(8'h1F, 3'd3, 1'b0, 32'h41E0_0000,  "R10 E3M2 max");
    drive(8'h07, 3'd4, 1'b0, 32'h40C0_0000,  "R10 E2M1 max");
    drive(8'h0F, 3'd4, 1'b0, 32'hC0C0_0000,  "R10 E2M1 -max");
    // R11
    drive(8'h38, 3'd5, 1'b0, NAN_W,          "R11 code5");
    drive(8'h00, 3'd6, 1'b1, NAN_W,          "R11 code6");
    drive(8'h3C, 3'd7, 1'b0, NAN_W,          "R11 code7");
    idle(1);
    // R2: single request then idle cycles
    drive(8'h38, 3'd0, 1'b0, 32'h3F80_0000,  "R2 single");
    idle(2);
    check("R2 strobe drops", out_valid_o, 32'd0);
    check("R2 result held", result_o, 32'h3F80_0000);

    // R4 sweep over every code, flag and lane value, back to back
    for (int f = 0; f < 8; f++) begin
      for (int z = 0; z < 2; z++) begin
        for (int e = 0; e < 256; e++) begin
          drive(8'(e), 3'(f), z[0], ref_word(8'(e), f, z[0]), "R4 sweep");
        end
      end
    end
    idle(3);
    check("R2 idle after stream", out_valid_o, 32'd0);
    check("R2 hold after stream", result_o, NAN_W);
    check("R2 all results seen", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule